// File: doc/BRIEF.md
# Programmable Bit Clock and Frame Sync Generator

This block derives a serial bit clock and a periodic frame sync from a slower input clock. The input clock is sampled in the system clock domain. Either its rising or its falling edges are counted, and every `div_val + 1` counted edges make one bit period. The outputs are single-cycle enable strobes that mark the rising and falling transitions of the generated bit clock. A frame-sync level and a frame-start strobe are also produced, and both are timed in generated bit clocks.

The frame period and the pulse width are both counted in bit clocks. The period counter counts down and reloads itself each time it expires. The width counter keeps the sync active for a programmed number of bit clocks. When resync is enabled, a rising edge on an external frame sync forces the divider back to its starting phase. The same edge restarts the frame, so two devices that divide the same source clock stay in step.

A generator reset clears the divider and the frame logic. After the reset is released, the first two bit clocks only settle the divider. The first frame starts on the third bit clock.

Top module: `bitclk_frame_gen`

## Requirements
- R1: `bclk_rise` pulses for one cycle once every `div_val + 1` counted input-clock edges. The pulse appears in the cycle after the edge that completes the count is sampled.
- R2: With `div_val = 0`, every counted input edge produces a `bclk_rise` pulse, and `bclk_fall` never pulses.
- R3: With `src_rise_sel = 1`, only low-to-high changes of `src_clk` are counted. With `src_rise_sel = 0`, only high-to-low changes are counted.
- R4: With `div_val > 0`, `bclk_fall` pulses after ceil((`div_val`+1)/2) counted edges past the last rise. The high phase is therefore the same length as the low phase, or one edge longer. `bclk_rise` and `bclk_fall` never pulse together.
- R5: Once the generator is running, `fs_start` pulses on every (`fs_period` + 1)-th `bclk_rise`, and always together with a `bclk_rise`. The 12-bit period counter reloads on expiry, so a period of 4095 gives 4096 bit clocks.
- R6: `fsync` rises with `fs_start` and stays high for `fs_width + 1` bit clocks. If `fs_width >= fs_period`, it stays high continuously. `fsync` only changes together with a `bclk_rise` pulse or after a generator reset.
- R7: When `resync_en = 1`, a sampled rising edge of `ext_fs` does three things in the next cycle. It restarts the divider phase, it emits a `bclk_rise`, and it starts a new frame, provided the warm-up of R9 is complete. If a counted input edge arrives in the same cycle, it is dropped.
- R8: When `resync_en = 0`, `ext_fs` has no effect on any output.
- R9: After `gen_rst` is released, the first two `bclk_rise` pulses start no frame. The first `fs_start` comes with the third pulse.
- R10: While `rst_n` is low, and in the cycle after `gen_rst` is sampled high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| gen_rst | input | 1 | Synchronous generator reset, active high |
| src_clk | input | 1 | Input clock level to be divided |
| src_rise_sel | input | 1 | 1: count rising edges of `src_clk`, 0: count falling edges |
| div_val | input | 8 | Bit-clock divide setting (ratio = value + 1) |
| fs_width | input | 8 | Frame-sync active length minus one, in bit clocks |
| fs_period | input | 12 | Frame period minus one, in bit clocks |
| resync_en | input | 1 | Enables realignment to `ext_fs` |
| ext_fs | input | 1 | External frame sync level |
| bclk_rise | output | 1 | Strobe at each bit-clock rising transition |
| bclk_fall | output | 1 | Strobe at each bit-clock falling transition |
| fsync | output | 1 | Frame-sync level |
| fs_start | output | 1 | Strobe at the first bit clock of each frame |

## Verification
The bench builds the block with its default widths: an 8-bit divider, an 8-bit width and a 12-bit period. With these widths the period can be set to 4095, so reload at the full counter range is exercised over more than one frame. The bench switches the input-clock half period between one and three system cycles and selects both edge polarities. It runs divide ratios of one, two, three, four, five and six, which cover both duty-cycle cases. It applies width settings below and above the period, and drives external sync edges at spacings unrelated to the bit clock, with resync both enabled and disabled.

// File: rtl/bitclk_frame_gen.sv
module bitclk_frame_gen #(
  parameter int DIV_W = 8,
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_rst,
  input  logic             src_clk,
  input  logic             src_rise_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic [WID_W-1:0] fs_width,
  input  logic [PER_W-1:0] fs_period,
  input  logic             resync_en,
  input  logic             ext_fs,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic             fsync,
  output logic             fs_start
);
  localparam logic [DIV_W:0] ONE = 1;
  localparam logic [DIV_W:0] TWO = 2;
  localparam logic [1:0]     WARM_TICKS = 2'd2;

  logic             src_q, ext_q;
  logic [DIV_W-1:0] cnt;
  logic [PER_W-1:0] per_cnt;
  logic [WID_W-1:0] wid_cnt;
  logic [1:0]       warm;

  wire             src_ev  = src_rise_sel ? (src_clk & ~src_q) : (~src_clk & src_q);
  wire             ext_ev  = resync_en & ext_fs & ~ext_q;
  wire             wrap    = cnt >= div_val;
  wire             tick    = ext_ev | (src_ev & wrap);
  wire [DIV_W:0]   half    = ({1'b0, div_val} + TWO) >> 1;
  wire             fall_ev = ~ext_ev & src_ev & ~wrap & (div_val != '0) &
                             (({1'b0, cnt} + ONE) == half);
  wire             running = warm == WARM_TICKS;
  wire             restart = ext_ev | (per_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      src_q <= src_clk;
      ext_q <= ext_fs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      warm      <= '0;
      bclk_rise <= 1'b0;
      bclk_fall <= 1'b0;
    end else if (gen_rst) begin
      cnt       <= '0;
      warm      <= '0;
      bclk_rise <= 1'b0;
      bclk_fall <= 1'b0;
    end else begin
      bclk_rise <= tick;
      bclk_fall <= fall_ev;
      if (ext_ev || (src_ev && wrap)) cnt <= '0;
      else if (src_ev)                cnt <= cnt + 1'b1;
      if (tick && !running) warm <= warm + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= '0;
      wid_cnt  <= '0;
      fsync    <= 1'b0;
      fs_start <= 1'b0;
    end else if (gen_rst) begin
      per_cnt  <= '0;
      wid_cnt  <= '0;
      fsync    <= 1'b0;
      fs_start <= 1'b0;
    end else begin
      fs_start <= tick & running & restart;
      if (tick && running) begin
        if (restart) begin
          per_cnt <= fs_period;
          wid_cnt <= fs_width;
          fsync   <= 1'b1;
        end else begin
          per_cnt <= per_cnt - 1'b1;
          if (fsync) begin
            if (wid_cnt == '0) fsync <= 1'b0;
            else               wid_cnt <= wid_cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bitclk_frame_gen_chk.sv
module bitclk_frame_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_rst,
  input logic [DIV_W-1:0] div_val,
  input logic             bclk_rise,
  input logic             bclk_fall,
  input logic             fsync,
  input logic             fs_start
);
  assert_no_double_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_rise && bclk_fall));

  assert_no_fall_undivided_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) && $stable(div_val) |=> !bclk_fall);

  assert_start_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fs_start |-> bclk_rise && fsync);

  assert_sync_rises_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> fs_start);

  assert_sync_moves_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_rise && !$past(gen_rst) |-> $stable(fsync));

  assert_quiet_after_genrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rst |=> !bclk_rise && !bclk_fall && !fsync && !fs_start);
endmodule

bind bitclk_frame_gen bitclk_frame_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_rst(gen_rst), .div_val(div_val),
  .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fsync(fsync), .fs_start(fs_start)
);

// File: tb/bitclk_frame_gen_bench.sv
module bitclk_frame_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, gen_rst = 1'b0, src_clk = 1'b0, src_rise_sel = 1'b1;
  logic [7:0] div_val = '0, fs_width = '0;
  logic [11:0] fs_period = '0;
  logic resync_en = 1'b0, ext_fs = 1'b0;
  logic bclk_rise, bclk_fall, fsync, fs_start;

  always #5 clk = ~clk;

  bitclk_frame_gen u_bitclk_frame_gen (.*);

  int vectors = 0, misses = 0;
  string cur_req = "R10";
  int hp = 1, hcnt = 0, ext_every = 0, cyc = 0;

  bit e_rise, e_fall, e_fsync, e_start;
  int p, k, warm;
  bit started, prev_src, prev_ext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rise = 0; e_fall = 0; e_fsync = 0; e_start = 0;
      p = 0; k = 0; warm = 0; started = 0; prev_src = 0; prev_ext = 0;
    end else begin
      bit ev, xe, r;
      int n;
      ev = src_rise_sel ? (src_clk && !prev_src) : (!src_clk && prev_src);
      xe = resync_en && ext_fs && !prev_ext;
      prev_src = src_clk;
      prev_ext = ext_fs;
      e_rise = 0; e_fall = 0; e_start = 0;
      if (gen_rst) begin
        p = 0; k = 0; warm = 0; started = 0; e_fsync = 0;
      end else begin
        n = int'(div_val) + 1;
        r = 0;
        if (xe) begin
          p = 0; r = 1;
        end else if (ev) begin
          p = p + 1;
          if (p >= n) begin p = 0; r = 1; end
          else if (p == (n + 1) / 2) e_fall = 1;
        end
        if (r) begin
          e_rise = 1;
          if (warm < 2) warm = warm + 1;
          else begin
            if (xe || !started || k >= int'(fs_period)) begin
              k = 0; started = 1; e_start = 1;
            end else k = k + 1;
            e_fsync = (k <= int'(fs_width));
          end
        end
      end
    end
  end

  task automatic cmp(input string what, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", cur_req, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmp("bclk_rise", bclk_rise, e_rise);
    cmp("bclk_fall", bclk_fall, e_fall);
    cmp("fsync", fsync, e_fsync);
    cmp("fs_start", fs_start, e_start);
    cyc++;
    hcnt++;
    if (hcnt >= hp) begin src_clk = ~src_clk; hcnt = 0; end
    ext_fs = (ext_every > 0) && ((cyc % ext_every) < 2);
  endtask

  task automatic scenario(input string req, input int d, input int fw, input int fp,
                          input bit rs, input bit rsy, input int xe, input int h, input int n);
    cur_req = req;
    @(negedge clk);
    gen_rst = 1'b1;
    div_val = 8'(d); fs_width = 8'(fw); fs_period = 12'(fp);
    src_rise_sel = rs; resync_en = rsy; ext_every = xe; hp = h;
    repeat (3) step();
    gen_rst = 1'b0;
    repeat (n) step();
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    cur_req = "R10";
    repeat (4) step();
    rst_n = 1'b1;
    gen_rst = 1'b1;
    repeat (4) step();
    scenario("R2", 0, 1, 3, 1'b1, 1'b0, 0, 2, 200);
    scenario("R1", 3, 2, 5, 1'b1, 1'b0, 0, 1, 400);
    scenario("R3", 3, 2, 5, 1'b0, 1'b0, 0, 3, 400);
    scenario("R4", 4, 0, 2, 1'b1, 1'b0, 0, 1, 300);
    scenario("R4", 5, 1, 3, 1'b0, 1'b0, 0, 2, 300);
    scenario("R6", 1, 7, 3, 1'b1, 1'b0, 0, 1, 300);
    scenario("R9", 2, 1, 6, 1'b1, 1'b0, 0, 2, 200);
    scenario("R7", 5, 1, 9, 1'b1, 1'b1, 37, 1, 1500);
    scenario("R8", 5, 1, 9, 1'b1, 1'b0, 37, 1, 800);
    scenario("R5", 0, 0, 4095, 1'b1, 1'b0, 0, 1, 16500);
    cur_req = "R10";
    gen_rst = 1'b1;
    repeat (3) step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule